// File: doc/BRIEF.md
# Two-Cache Write-Invalidate Snooping Coherence Controller

This block joins two processor ports to one shared word memory. Each port has its own private direct-mapped write-back cache. The two caches share one arbitrated bus and stay coherent by watching it. Every transaction that one cache places on the bus is looked up in the other cache in the same cycle. A write to a line the other cache also holds removes that copy. A read of a line the other cache holds dirty is answered with the dirty word, which is written into memory at the same time.

A processor raises its request with a read/write flag, an address and write data, and holds them until a one-cycle done pulse arrives. Read data is valid while done is high. The bus command, address and owner are visible at the ports so that the coherence traffic can be observed. A read-only peek port returns any memory word, so the effect of write-back and flush can be seen.

Top module: `snoop_pair_coherence`

## Requirements
- R1: After reset, every cache line is Invalid, done is low on both ports, no bus transaction is active, and memory holds the two seeded words (address 1 = 20, address 2 = 10, all others 0).
- R2: A read miss places a read command (bus_cmd 0) on the bus and returns the current value of the block. The line is then held Shared.
- R3: A read hit, or a write hit on a Modified line, completes with done one clock edge after the request, with no bus transaction.
- R4: A write to a line held Shared issues an invalidate command (bus_cmd 2). The other cache's copy is dropped, so that cache's next read of the block misses and returns the new value.
- R5: When a cache snoops a read of a block it holds Modified, it supplies that word in place of memory and writes it to memory in the same cycle. The cache then keeps the line Shared.
- R6: A write miss issues a read-for-ownership command (bus_cmd 1). Any other copy is invalidated, and a Modified copy in the other cache is flushed to memory first.
- R7: A miss whose direct-mapped slot (address bits [1:0]) holds a different Modified block first writes that block back (bus_cmd 3), then fetches the new block.
- R8: Blocks in different slots are independent: an access to one block does not change another block's data or state.
- R9: The bus is granted to at most one cache per cycle, only to a requesting cache. When both caches request together, both complete, in different cycles.
- R10: done is a single-cycle pulse per request.
- R11: A write hit updates only the cache. Memory keeps the old value until the line is flushed or written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p0_req | input | 1 | Port 0 request, held until p0_done |
| p0_we | input | 1 | Port 0 write (1) or read (0) |
| p0_addr | input | ADDR_W | Port 0 word address |
| p0_wdata | input | DATA_W | Port 0 write data |
| p0_done | output | 1 | Port 0 completion pulse |
| p0_rdata | output | DATA_W | Port 0 read data, valid with p0_done |
| p1_req | input | 1 | Port 1 request, held until p1_done |
| p1_we | input | 1 | Port 1 write (1) or read (0) |
| p1_addr | input | ADDR_W | Port 1 word address |
| p1_wdata | input | DATA_W | Port 1 write data |
| p1_done | output | 1 | Port 1 completion pulse |
| p1_rdata | output | DATA_W | Port 1 read data, valid with p1_done |
| bus_valid | output | 1 | A bus transaction is in progress this cycle |
| bus_owner | output | 1 | Cache that holds the bus (0 or 1) |
| bus_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 invalidate, 3 write-back |
| bus_addr | output | ADDR_W | Block address on the bus |
| peek_addr | input | ADDR_W | Memory peek address |
| peek_data | output | DATA_W | Memory word at peek_addr |

## Verification
The two-processor interleaving is replayed first: two reads of one block, a write by one side, a read by the other, then a second block read and written. This separates a stale read from a correct invalidate-and-refetch, and it shows that an invalidate, not a fetch, is used for a write to a Shared line. Directed patterns follow. A remote read of a dirty block separates flushing from reading stale memory. Two writes to an unheld block show read-for-ownership, and an index conflict on a dirty slot shows write-back ordering. Simultaneous misses from both ports show that arbitration serializes them without loss.

// File: rtl/coh_pkg.sv
package coh_pkg;
   typedef enum logic [1:0] {
      LN_INV = 2'd0,
      LN_SHR = 2'd1,
      LN_MOD = 2'd2
   } line_st_e;

   typedef enum logic [1:0] {
      BUS_RD  = 2'd0,
      BUS_RDX = 2'd1,
      BUS_UPG = 2'd2,
      BUS_WB  = 2'd3
   } bus_cmd_e;
endpackage

// File: rtl/coh_arbiter.sv
module coh_arbiter #(
   parameter bit ROUND_ROBIN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] req,
   output logic [1:0] gnt
);
   generate
      if (ROUND_ROBIN) begin : g_rr
         logic last_one;
         always_comb begin
            gnt[1] = req[1] && (!req[0] || !last_one);
            gnt[0] = req[0] && !gnt[1];
         end
         always_ff @(posedge clk) begin
            if (!rst_n)      last_one <= 1'b1;
            else if (|gnt)   last_one <= gnt[1];
         end
      end else begin : g_fixed
         always_comb begin
            gnt[0] = req[0];
            gnt[1] = req[1] && !req[0];
         end
      end
   endgenerate

   a_r9_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
   a_r9_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      |(gnt & ~req) == 1'b0);
endmodule

// File: rtl/coh_memory.sv
module coh_memory #(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 8,
   parameter int SEED_A_ADDR = 1,
   parameter int SEED_A_VAL  = 20,
   parameter int SEED_B_ADDR = 2,
   parameter int SEED_B_VAL  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic [ADDR_W-1:0] peek_addr,
   output logic [DATA_W-1:0] peek_data
);
   localparam int WORDS = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [WORDS];

   assign rd_data   = mem[rd_addr];
   assign peek_data = mem[peek_addr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int w = 0; w < WORDS; w++) begin
            if (w == SEED_A_ADDR)      mem[w] <= DATA_W'(SEED_A_VAL);
            else if (w == SEED_B_ADDR) mem[w] <= DATA_W'(SEED_B_VAL);
            else                       mem[w] <= '0;
         end
      end else if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end
endmodule

// File: rtl/coh_cache.sv
module coh_cache
   import coh_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8,
   parameter int LINES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic              bus_req,
   output bus_cmd_e          bus_cmd_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic [DATA_W-1:0] bus_wdata_o,
   input  logic              grant,
   input  logic [DATA_W-1:0] fill_data,
   input  logic              snp_valid,
   input  bus_cmd_e          snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_flush,
   output logic [DATA_W-1:0] snp_data
);
   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = ADDR_W - IDX_W;

   line_st_e          st   [LINES];
   logic [TAG_W-1:0]  tags [LINES];
   logic [DATA_W-1:0] dat  [LINES];

   logic [IDX_W-1:0] idx, s_idx;
   logic [TAG_W-1:0] tg, s_tg;
   logic active, hit, local_able, local_ok, victim_dirty, snp_hit, done_q;

   assign idx   = addr[IDX_W-1:0];
   assign tg    = addr[ADDR_W-1:IDX_W];
   assign s_idx = snp_addr[IDX_W-1:0];
   assign s_tg  = snp_addr[ADDR_W-1:IDX_W];

   assign active       = req && !done_q;
   assign hit          = (st[idx] != LN_INV) && (tags[idx] == tg);
   assign local_able   = hit && (!we || st[idx] == LN_MOD);
   assign local_ok     = active && local_able && !(snp_valid && s_idx == idx);
   assign victim_dirty = (st[idx] == LN_MOD) && (tags[idx] != tg);
   assign bus_req      = active && !local_able;

   always_comb begin
      if (victim_dirty)  bus_cmd_o = BUS_WB;
      else if (!we)      bus_cmd_o = BUS_RD;
      else if (hit)      bus_cmd_o = BUS_UPG;
      else               bus_cmd_o = BUS_RDX;
   end

   assign bus_addr_o  = (bus_cmd_o == BUS_WB) ? {tags[idx], idx} : addr;
   assign bus_wdata_o = dat[idx];

   assign snp_hit   = snp_valid && (st[s_idx] != LN_INV) && (tags[s_idx] == s_tg);
   assign snp_flush = snp_hit && (st[s_idx] == LN_MOD) &&
                      (snp_cmd == BUS_RD || snp_cmd == BUS_RDX);
   assign snp_data  = dat[s_idx];

   assign done = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int l = 0; l < LINES; l++) begin
            st[l]   <= LN_INV;
            tags[l] <= '0;
            dat[l]  <= '0;
         end
         done_q <= 1'b0;
         rdata  <= '0;
      end else begin
         done_q <= (grant && bus_cmd_o != BUS_WB) || local_ok;
         if (snp_hit) begin
            case (snp_cmd)
               BUS_RD:          if (st[s_idx] == LN_MOD) st[s_idx] <= LN_SHR;
               BUS_RDX, BUS_UPG: st[s_idx] <= LN_INV;
               default: ;
            endcase
         end
         if (grant) begin
            case (bus_cmd_o)
               BUS_WB: st[idx] <= LN_INV;
               BUS_RD: begin
                  st[idx]   <= LN_SHR;
                  tags[idx] <= tg;
                  dat[idx]  <= fill_data;
                  rdata     <= fill_data;
               end
               default: begin
                  st[idx]   <= LN_MOD;
                  tags[idx] <= tg;
                  dat[idx]  <= wdata;
               end
            endcase
         end else if (local_ok) begin
            if (we) dat[idx] <= wdata;
            else    rdata    <= dat[idx];
         end
      end
   end

   a_r4_snoop_invalidates: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_hit && (snp_cmd == BUS_UPG || snp_cmd == BUS_RDX))
      |=> st[$past(s_idx)] == LN_INV);
   a_r5_flush_leaves_shared: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_flush && snp_cmd == BUS_RD) |=> st[$past(s_idx)] == LN_SHR);
   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
endmodule

// File: rtl/snoop_pair_coherence.sv
module snoop_pair_coherence
   import coh_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 8,
   parameter int LINES       = 4,
   parameter bit ARB_RR      = 1'b1,
   parameter int SEED_A_ADDR = 1,
   parameter int SEED_A_VAL  = 20,
   parameter int SEED_B_ADDR = 2,
   parameter int SEED_B_VAL  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              p0_req,
   input  logic              p0_we,
   input  logic [ADDR_W-1:0] p0_addr,
   input  logic [DATA_W-1:0] p0_wdata,
   output logic              p0_done,
   output logic [DATA_W-1:0] p0_rdata,
   input  logic              p1_req,
   input  logic              p1_we,
   input  logic [ADDR_W-1:0] p1_addr,
   input  logic [DATA_W-1:0] p1_wdata,
   output logic              p1_done,
   output logic [DATA_W-1:0] p1_rdata,
   output logic              bus_valid,
   output logic              bus_owner,
   output logic [1:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   input  logic [ADDR_W-1:0] peek_addr,
   output logic [DATA_W-1:0] peek_data
);
   localparam int IDX_W = $clog2(LINES);

   generate
      if (LINES < 2 || (1 << IDX_W) != LINES) begin : g_bad_lines
         $error("LINES must be a power of two of at least 2");
      end
      if (IDX_W >= ADDR_W) begin : g_bad_addr
         $error("ADDR_W must leave at least one tag bit");
      end
      if ((SEED_A_ADDR % LINES) == (SEED_B_ADDR % LINES)) begin : g_bad_seed
         $error("seeded words must sit in different cache slots");
      end
   endgenerate

   logic              c_req   [2];
   logic              c_we    [2];
   logic [ADDR_W-1:0] c_addr  [2];
   logic [DATA_W-1:0] c_wdata [2];
   logic              c_done  [2];
   logic [DATA_W-1:0] c_rdata [2];
   bus_cmd_e          c_cmd   [2];
   logic [ADDR_W-1:0] c_baddr [2];
   logic [DATA_W-1:0] c_bdata [2];
   logic              c_flush [2];
   logic [DATA_W-1:0] c_sdata [2];
   logic [1:0]        breq, gnt;

   bus_cmd_e          b_cmd;
   logic [ADDR_W-1:0] b_addr;
   logic [DATA_W-1:0] b_wdata, mem_rd, fill, flush_data;
   logic              flush_any, mem_we;
   logic [DATA_W-1:0] mem_wd;

   assign c_req[0] = p0_req;   assign c_req[1] = p1_req;
   assign c_we[0]  = p0_we;    assign c_we[1]  = p1_we;
   assign c_addr[0] = p0_addr; assign c_addr[1] = p1_addr;
   assign c_wdata[0] = p0_wdata; assign c_wdata[1] = p1_wdata;
   assign p0_done  = c_done[0];  assign p1_done  = c_done[1];
   assign p0_rdata = c_rdata[0]; assign p1_rdata = c_rdata[1];

   coh_arbiter #(.ROUND_ROBIN(ARB_RR)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(breq), .gnt(gnt)
   );

   assign bus_valid = |gnt;
   assign bus_owner = gnt[1];
   assign b_cmd     = gnt[1] ? c_cmd[1]   : c_cmd[0];
   assign b_addr    = gnt[1] ? c_baddr[1] : c_baddr[0];
   assign b_wdata   = gnt[1] ? c_bdata[1] : c_bdata[0];
   assign bus_cmd   = b_cmd;
   assign bus_addr  = b_addr;

   assign flush_any  = c_flush[0] || c_flush[1];
   assign flush_data = c_flush[0] ? c_sdata[0] : c_sdata[1];
   assign fill       = flush_any ? flush_data : mem_rd;
   assign mem_we     = bus_valid && (b_cmd == BUS_WB || flush_any);
   assign mem_wd     = (b_cmd == BUS_WB) ? b_wdata : flush_data;

   for (genvar i = 0; i < 2; i++) begin : g_cache
      coh_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_cache (
         .clk(clk), .rst_n(rst_n),
         .req(c_req[i]), .we(c_we[i]), .addr(c_addr[i]), .wdata(c_wdata[i]),
         .done(c_done[i]), .rdata(c_rdata[i]),
         .bus_req(breq[i]), .bus_cmd_o(c_cmd[i]), .bus_addr_o(c_baddr[i]),
         .bus_wdata_o(c_bdata[i]), .grant(gnt[i]), .fill_data(fill),
         .snp_valid(gnt[1-i]), .snp_cmd(b_cmd), .snp_addr(b_addr),
         .snp_flush(c_flush[i]), .snp_data(c_sdata[i])
      );
   end

   coh_memory #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .SEED_A_ADDR(SEED_A_ADDR), .SEED_A_VAL(SEED_A_VAL),
      .SEED_B_ADDR(SEED_B_ADDR), .SEED_B_VAL(SEED_B_VAL)
   ) u_mem (
      .clk(clk), .rst_n(rst_n),
      .wr_en(mem_we), .wr_addr(b_addr), .wr_data(mem_wd),
      .rd_addr(b_addr), .rd_data(mem_rd),
      .peek_addr(peek_addr), .peek_data(peek_data)
   );

   a_r5_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
      !(c_flush[0] && c_flush[1]));
   a_r5_flush_needs_bus: assert property (@(posedge clk) disable iff (!rst_n)
      flush_any |-> bus_valid);
endmodule

// File: tb/snoop_pair_coherence_test.sv
module snoop_pair_coherence_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       p0_req = 0, p0_we = 0, p1_req = 0, p1_we = 0;
   logic [3:0] p0_addr = 0, p1_addr = 0, peek_addr = 0, bus_addr;
   logic [7:0] p0_wdata = 0, p1_wdata = 0, p0_rdata, p1_rdata, peek_data;
   logic       p0_done, p1_done, bus_valid, bus_owner;
   logic [1:0] bus_cmd;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   snoop_pair_coherence uut (
      .clk(clk), .rst_n(rst_n),
      .p0_req(p0_req), .p0_we(p0_we), .p0_addr(p0_addr), .p0_wdata(p0_wdata),
      .p0_done(p0_done), .p0_rdata(p0_rdata),
      .p1_req(p1_req), .p1_we(p1_we), .p1_addr(p1_addr), .p1_wdata(p1_wdata),
      .p1_done(p1_done), .p1_rdata(p1_rdata),
      .bus_valid(bus_valid), .bus_owner(bus_owner), .bus_cmd(bus_cmd),
      .bus_addr(bus_addr), .peek_addr(peek_addr), .peek_data(peek_data)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic peek(input int a, output int v);
      @(negedge clk);
      peek_addr = 4'(a);
      #1;
      v = int'(peek_data);
   endtask

   // runs one request; first_cmd is -1 when the port never owned the bus
   task automatic run_op(input int p, input bit we, input int a, input int wd,
                         output int rd, output int first_cmd, output int cyc);
      bit got;
      @(negedge clk);
      if (p == 0) begin p0_req = 1; p0_we = we; p0_addr = 4'(a); p0_wdata = 8'(wd); end
      else        begin p1_req = 1; p1_we = we; p1_addr = 4'(a); p1_wdata = 8'(wd); end
      first_cmd = -1; cyc = 0; got = 0; rd = 0;
      for (int k = 0; k < 40; k++) begin
         #1;
         if (bus_valid && int'(bus_owner) == p && first_cmd < 0) first_cmd = int'(bus_cmd);
         @(negedge clk);
         cyc++;
         if ((p == 0 && p0_done) || (p == 1 && p1_done)) begin got = 1; break; end
      end
      rd = (p == 0) ? int'(p0_rdata) : int'(p1_rdata);
      p0_req = 0; p1_req = 0;
      chk(got, "R10 completion", int'(got), 1);
      @(negedge clk);
      chk(!(p0_done || p1_done), "R10 done pulse width", int'(p0_done | p1_done), 0);
   endtask

   // p, we, addr, wdata, expected read, expected first bus command (4 = none)
   localparam logic [31:0] VEC [7] = '{
      {1'b0, 1'b0, 2'b0, 4'd1, 8'd0,  8'd20, 5'd0, 3'd0},
      {1'b1, 1'b0, 2'b0, 4'd1, 8'd0,  8'd20, 5'd0, 3'd0},
      {1'b0, 1'b1, 2'b0, 4'd1, 8'd40, 8'd0,  5'd0, 3'd2},
      {1'b1, 1'b0, 2'b0, 4'd1, 8'd0,  8'd40, 5'd0, 3'd0},
      {1'b1, 1'b0, 2'b0, 4'd2, 8'd0,  8'd10, 5'd0, 3'd0},
      {1'b1, 1'b1, 2'b0, 4'd2, 8'd50, 8'd0,  5'd0, 3'd2},
      {1'b0, 1'b0, 2'b0, 4'd1, 8'd0,  8'd40, 5'd0, 3'd4}
   };

   initial begin
      #(4 * 20000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int rd, fc, cy, v, c0, c1;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      #1;
      chk(!p0_done && !p1_done, "R1 done low", int'(p0_done | p1_done), 0);
      chk(!bus_valid, "R1 bus idle", int'(bus_valid), 0);
      peek(1, v); chk(v == 20, "R1 seed A", v, 20);
      peek(2, v); chk(v == 10, "R1 seed B", v, 10);
      peek(5, v); chk(v == 0, "R1 other word", v, 0);

      // interleaved two-processor sequence (R2 R3 R4 R5 R8)
      foreach (VEC[i]) begin
         logic [31:0] e;
         e = VEC[i];
         run_op(int'(e[31]), e[30], int'(e[27:24]), int'(e[23:16]), rd, fc, cy);
         if (!e[30]) chk(rd == int'(e[15:8]), $sformatf("R2 R4 R5 vector %0d read", i), rd, int'(e[15:8]));
         if (e[2:0] == 3'd4) begin
            chk(fc == -1, $sformatf("R3 vector %0d no bus", i), fc, -1);
            chk(cy == 1, $sformatf("R3 vector %0d latency", i), cy, 1);
         end else begin
            chk(fc == int'(e[2:0]), $sformatf("R4 vector %0d bus command", i), fc, int'(e[2:0]));
         end
      end
      // R11 and R8: A flushed to 40 on remote read, B still old after write hit
      peek(1, v); chk(v == 40, "R5 memory A after flush", v, 40);
      peek(2, v); chk(v == 10, "R11 memory B not written through", v, 10);

      // R5 remote read of dirty B
      run_op(0, 0, 2, 0, rd, fc, cy);
      chk(rd == 50, "R5 dirty data supplied", rd, 50);
      peek(2, v); chk(v == 50, "R5 memory B updated", v, 50);

      // R4 write to Shared then other side rereads
      run_op(1, 1, 1, 77, rd, fc, cy);
      chk(fc == 2, "R4 invalidate command", fc, 2);
      run_op(0, 0, 1, 0, rd, fc, cy);
      chk(fc == 0, "R4 reader misses", fc, 0);
      chk(rd == 77, "R4 reader sees new value", rd, 77);

      // R3 write hit on Modified stays local
      run_op(0, 1, 3, 9, rd, fc, cy);
      chk(fc == 1, "R6 write miss ownership", fc, 1);
      run_op(0, 1, 3, 8, rd, fc, cy);
      chk(fc == -1 && cy == 1, "R3 write hit modified", fc, -1);
      peek(3, v); chk(v == 0, "R11 write hit not in memory", v, 0);
      run_op(1, 1, 3, 11, rd, fc, cy);
      chk(fc == 1, "R6 remote write miss", fc, 1);
      peek(3, v); chk(v == 8, "R6 dirty copy flushed first", v, 8);

      // R7 dirty victim written back before fill
      run_op(1, 0, 7, 0, rd, fc, cy);
      chk(fc == 3, "R7 write-back first", fc, 3);
      chk(rd == 0, "R7 new block value", rd, 0);
      peek(3, v); chk(v == 11, "R7 victim in memory", v, 11);
      run_op(0, 0, 3, 0, rd, fc, cy);
      chk(rd == 11 && fc == 0, "R6 old owner invalidated", rd, 11);
      peek(1, v); chk(v == 77, "R8 block A untouched", v, 77);

      // R9 simultaneous requests
      @(negedge clk);
      p0_req = 1; p0_we = 0; p0_addr = 4'd5;
      p1_req = 1; p1_we = 0; p1_addr = 4'd6;
      c0 = -1; c1 = -1;
      for (int k = 1; k < 20 && (c0 < 0 || c1 < 0); k++) begin
         @(negedge clk);
         if (p0_done) begin c0 = k; p0_req = 0; chk(p0_rdata == 0, "R9 port0 data", int'(p0_rdata), 0); end
         if (p1_done) begin c1 = k; p1_req = 0; chk(p1_rdata == 0, "R9 port1 data", int'(p1_rdata), 0); end
      end
      p0_req = 0; p1_req = 0;
      chk(c0 > 0 && c1 > 0, "R9 both complete", (c0 > 0) + (c1 > 0), 2);
      chk(c0 != c1, "R9 serialized", c0, c1 + 1);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule